// File: doc/BRIEF.md
# Serial Frame Bit Counter with Write Guard

This block tracks how many bits remain in the current frame of a serial shift engine. Software programs a 3-bit length code through a byte-wide write port. Bit 3 of the same byte is a guard flag, and the code is accepted only when that flag is 0. A start strobe loads the decoded frame length into an internal down-counter. Each bit-complete strobe from the shift engine then lowers the counter by one. When the last bit completes, the block raises a one-cycle end-of-frame pulse and the code field returns to 000.

Two frame formats are supported, selected by `fmt_i2c_i`. In the I2C-style format every frame carries an extra acknowledge slot, so code 000 stands for 9 bits and codes 1 to 7 stand for 2 to 8 bits. In the clocked synchronous format code 000 stands for 8 bits and codes 1 to 7 stand for 1 to 7 bits. During a frame, a read returns the remaining bit count re-encoded in the same code space.

Top module: `xfer_bit_counter`

## Requirements
- R1: While `rst_n` is low, and in the cycle after `soft_rst_i` is sampled high, the code field reads 000, any frame in progress is abandoned and `frame_done_o` is 0. A soft reset takes priority over every other input.
- R2: When the frame is idle, the format is I2C-style and the SCL condition of R7 allows it, a write (`wr_en_i` high) with `wr_data_i[3]`=0 stores `wr_data_i[2:0]` as the code. A write with `wr_data_i[3]`=1 leaves the code unchanged.
- R3: `rd_data_o[3]` always reads 1, and `rd_data_o[2:0]` is the code field.
- R4: In I2C-style format (`fmt_i2c_i`=1), a frame started with code 000 lasts 9 bit strobes, and a frame started with code c in 1..7 lasts c+1 strobes.
- R5: In clocked synchronous format (`fmt_i2c_i`=0), a frame started with code 000 lasts 8 bit strobes, and a frame started with code c in 1..7 lasts c strobes.
- R6: While a frame runs with n bits remaining, the field reads (n-1) mod 8 in I2C-style format and n mod 8 in synchronous format.
- R7: In I2C-style format, a write of a nonzero code is ignored while `scl_level_i` is 1. A write of code 000 is still accepted.
- R8: In synchronous format, every write to the code is ignored.
- R9: The cycle after the edge that samples the last `bit_done_i` of a frame, `frame_done_o` is 1 for exactly one cycle and the field reads 000.
- R10: While a frame runs, `start_i` and writes are ignored. When `start_i` and a write arrive in the same idle cycle, the start wins and the write is dropped.
- R11: `bit_done_i` has no effect while no frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous module soft reset |
| fmt_i2c_i | input | 1 | 1 = I2C-style format with acknowledge slot, 0 = clocked synchronous format |
| scl_level_i | input | 1 | Current level of the serial clock line |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data: [3] = guard flag, [2:0] = length code |
| start_i | input | 1 | Frame start strobe |
| bit_done_i | input | 1 | One bit shifted |
| rd_data_o | output | 4 | Read value: [3] = 1, [2:0] = code or remaining count |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
On every cycle, the in-line assertions check four things:
- guarded writes, synchronous-format writes and nonzero writes with SCL high leave the code untouched;
- a soft reset empties the counter;
- a running count drops by exactly one per strobe, and an idle counter stays at zero;
- the end pulse lasts one cycle and comes with a 000 field.

Only the bench's scenarios can show the frame length that every code gives in both formats. They also show the re-encoded mid-frame readings, the start-beats-write ordering, and abandonment by a soft reset in mid-frame. The bench compares these against a behavioural model on every clock.

// File: rtl/xbc_pkg.sv
package xbc_pkg;
    localparam int CODE_W = 3;
    localparam int REM_W  = 4;

    typedef struct packed {
        logic [REM_W-1:0] rem;
        logic             active;
        logic             done;
    } cnt_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } reg_state_t;
endpackage

// File: rtl/xbc_wr_filter.sv
module xbc_wr_filter
    import xbc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PROT_BIT = 3
) (
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              fmt_i2c_i,
    input  logic              scl_level_i,
    input  logic              busy_i,
    output logic              accept_o,
    output logic [CODE_W-1:0] new_code_o
);
    logic guard_set;
    logic scl_block;

    always_comb begin
        new_code_o = wr_data_i[CODE_W-1:0];
        guard_set  = wr_data_i[PROT_BIT];
        scl_block  = scl_level_i && (new_code_o != '0);
        accept_o   = wr_en_i && !guard_set && fmt_i2c_i && !busy_i && !scl_block;
    end
endmodule

// File: rtl/xbc_len_codec.sv
module xbc_len_codec
    import xbc_pkg::*;
(
    input  logic              fmt_i2c_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [REM_W-1:0]  rem_i,
    output logic [REM_W-1:0]  len_o,
    output logic [CODE_W-1:0] field_o
);
    localparam logic [REM_W-1:0] FULL_SYNC = REM_W'(1 << CODE_W);

    logic [REM_W-1:0] ack_bits;
    logic [REM_W-1:0] shifted;

    always_comb begin
        ack_bits = fmt_i2c_i ? REM_W'(1) : '0;
        if (code_i == '0) begin
            len_o = FULL_SYNC + ack_bits;
        end else begin
            len_o = REM_W'(code_i) + ack_bits;
        end
        shifted = rem_i - ack_bits;
        field_o = shifted[CODE_W-1:0];
    end
endmodule

// File: rtl/xbc_down_counter.sv
module xbc_down_counter
    import xbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst_i,
    input  logic             start_i,
    input  logic             bit_done_i,
    input  logic [REM_W-1:0] load_len_i,
    output logic [REM_W-1:0] rem_o,
    output logic             active_o,
    output logic             frame_end_o,
    output logic             frame_done_o
);
    cnt_state_t st_d, st_q;
    logic       last_bit;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        last_bit  = st_q.active && bit_done_i && (st_q.rem <= REM_W'(1));
        if (soft_rst_i) begin
            st_d = '0;
        end else if (st_q.active) begin
            if (last_bit) begin
                st_d.rem    = '0;
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
            end else if (bit_done_i) begin
                st_d.rem = st_q.rem - REM_W'(1);
            end
        end else if (start_i) begin
            st_d.rem    = load_len_i;
            st_d.active = (load_len_i != '0);
        end
        frame_end_o = last_bit && !soft_rst_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rem_o        = st_q.rem;
    assign active_o     = st_q.active;
    assign frame_done_o = st_q.done;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |=> !frame_done_o);

    // R1
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_i |=> (rem_o == '0 && !active_o && !frame_done_o));

    // R6
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && bit_done_i && rem_o > REM_W'(1) && !soft_rst_i)
            |=> (rem_o == $past(rem_o) - REM_W'(1)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_o && !start_i) |=> (!active_o && rem_o == '0));
endmodule

// File: rtl/xfer_bit_counter.sv
module xfer_bit_counter
    import xbc_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int PROT_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst_i,
    input  logic              fmt_i2c_i,
    input  logic              scl_level_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              start_i,
    input  logic              bit_done_i,
    output logic [CODE_W:0]   rd_data_o,
    output logic              frame_done_o
);
    reg_state_t        rg_d, rg_q;
    logic              accept;
    logic [CODE_W-1:0] new_code;
    logic [REM_W-1:0]  load_len;
    logic [REM_W-1:0]  rem;
    logic [CODE_W-1:0] run_field;
    logic              active;
    logic              frame_end;
    logic              busy;

    assign busy = active || start_i;

    xbc_wr_filter #(.DATA_W(DATA_W), .PROT_BIT(PROT_BIT)) i_filter (
        .wr_en_i     (wr_en_i),
        .wr_data_i   (wr_data_i),
        .fmt_i2c_i   (fmt_i2c_i),
        .scl_level_i (scl_level_i),
        .busy_i      (busy),
        .accept_o    (accept),
        .new_code_o  (new_code)
    );

    xbc_len_codec i_codec (
        .fmt_i2c_i (fmt_i2c_i),
        .code_i    (rg_q.code),
        .rem_i     (rem),
        .len_o     (load_len),
        .field_o   (run_field)
    );

    xbc_down_counter i_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst_i   (soft_rst_i),
        .start_i      (start_i),
        .bit_done_i   (bit_done_i),
        .load_len_i   (load_len),
        .rem_o        (rem),
        .active_o     (active),
        .frame_end_o  (frame_end),
        .frame_done_o (frame_done_o)
    );

    always_comb begin
        rg_d = rg_q;
        if (soft_rst_i || frame_end) begin
            rg_d.code = '0;
        end else if (accept) begin
            rg_d.code = new_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign rd_data_o = {1'b1, (active ? run_field : rg_q.code)};

    // R2
    guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[PROT_BIT] && !active && !start_i && !soft_rst_i)
            |=> $stable(rg_q.code));

    // R8
    sync_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !fmt_i2c_i && !active && !start_i && !soft_rst_i)
            |=> $stable(rg_q.code));

    // R7
    scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && fmt_i2c_i && scl_level_i && wr_data_i[CODE_W-1:0] != '0
         && !active && !start_i && !soft_rst_i) |=> $stable(rg_q.code));

    // R9
    end_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done_o |-> (rd_data_o[CODE_W-1:0] == '0));
endmodule

// File: tb/test_xfer_bit_counter.sv
module test_xfer_bit_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       fmt = 1'b1;
    logic       scl = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       start = 1'b0;
    logic       bit_done = 1'b0;
    logic [3:0] rd_data;
    logic       frame_done;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";

    int m_code = 0;
    int m_rem = 0;
    int m_active = 0;
    int m_done = 0;

    always #2.5 clk = ~clk;

    xfer_bit_counter i_xfer_bit_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst_i   (soft_rst),
        .fmt_i2c_i    (fmt),
        .scl_level_i  (scl),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .start_i      (start),
        .bit_done_i   (bit_done),
        .rd_data_o    (rd_data),
        .frame_done_o (frame_done)
    );

    function automatic int frame_len(int code, logic i2c);
        if (i2c) return (code == 0) ? 9 : code + 1;
        return (code == 0) ? 8 : code;
    endfunction

    // behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_code = 0; m_rem = 0; m_active = 0; m_done = 0;
        end else if (soft_rst) begin
            m_code = 0; m_rem = 0; m_active = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_active != 0) begin
                if (bit_done) begin
                    if (m_rem == 1) begin
                        m_rem = 0; m_active = 0; m_code = 0; m_done = 1;
                    end else begin
                        m_rem = m_rem - 1;
                    end
                end
            end else if (start) begin
                m_rem = frame_len(m_code, fmt);
                m_active = 1;
            end else if (wr_en && !wr_data[3] && fmt && !(scl && wr_data[2:0] != 0)) begin
                m_code = int'(wr_data[2:0]);
            end
        end
    end

    function automatic int exp_field();
        if (m_active != 0) return ((m_rem - (fmt ? 1 : 0)) % 8 + 8) % 8;
        return m_code;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock comparison, away from the active edge (R3 on every cycle)
    always @(negedge clk) begin
        chk(rd_data[3] === 1'b1, "R3", int'(rd_data[3]), 1);
        chk(rd_data[2:0] === 3'(exp_field()), cur_req, int'(rd_data[2:0]), exp_field());
        chk(frame_done === (m_done != 0), cur_req, int'(frame_done), m_done);
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic run_frame(input int gap, output int n);
        start = 1'b1;
        step();
        start = 1'b0;
        n = 0;
        for (int k = 0; k < 20; k++) begin
            bit_done = 1'b1;
            step();
            bit_done = 1'b0;
            n++;
            if (frame_done) break;
            for (int g = 0; g < gap; g++) step();
        end
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        repeat (3) step();
        // R1: reset state
        chk(rd_data === 4'b1000, "R1", int'(rd_data), 8);
        chk(frame_done === 1'b0, "R1", int'(frame_done), 0);
        rst_n = 1'b1;
        step();

        // R4: I2C-style lengths for every code, R6 mid-frame readings via model
        fmt = 1'b1;
        for (int c = 0; c < 8; c++) begin
            cur_req = "R2";
            do_write(8'(c));
            chk(rd_data[2:0] === 3'(c), "R2", int'(rd_data[2:0]), c);
            cur_req = "R6";
            run_frame(c % 2, n);
            chk(n == frame_len(c, 1'b1), "R4", n, frame_len(c, 1'b1));
            chk(rd_data[2:0] === 3'd0, "R9", int'(rd_data[2:0]), 0);
            step();
            chk(frame_done === 1'b0, "R9", int'(frame_done), 0);
        end

        // R6: explicit reading after start and one bit with code 000
        cur_req = "R6";
        do_write(8'h00);
        start = 1'b1; step(); start = 1'b0;
        chk(rd_data[2:0] === 3'd0, "R6", int'(rd_data[2:0]), 0);
        bit_done = 1'b1; step(); bit_done = 1'b0;
        chk(rd_data[2:0] === 3'd7, "R6", int'(rd_data[2:0]), 7);
        // R10: writes and start ignored during a frame
        cur_req = "R10";
        do_write(8'h03);
        start = 1'b1; step(); start = 1'b0;
        chk(rd_data[2:0] === 3'd7, "R10", int'(rd_data[2:0]), 7);
        for (int k = 0; k < 8; k++) begin
            bit_done = 1'b1; step(); bit_done = 1'b0;
        end
        chk(frame_done === 1'b1, "R10", int'(frame_done), 1);
        step();

        // R10: start and write in the same idle cycle, start wins
        do_write(8'h02);
        wr_en = 1'b1; wr_data = 8'h06; start = 1'b1;
        step();
        wr_en = 1'b0; start = 1'b0;
        chk(rd_data[2:0] === 3'd2, "R10", int'(rd_data[2:0]), 2);
        for (int k = 0; k < 3; k++) begin
            bit_done = 1'b1; step(); bit_done = 1'b0;
        end
        chk(frame_done === 1'b1, "R10", int'(frame_done), 1);
        step();

        // R2: guarded write keeps the old code
        cur_req = "R2";
        do_write(8'h03);
        do_write(8'h0D);
        chk(rd_data[2:0] === 3'd3, "R2", int'(rd_data[2:0]), 3);
        do_write(8'hF5);
        chk(rd_data[2:0] === 3'd5, "R2", int'(rd_data[2:0]), 5);

        // R7: SCL high blocks nonzero writes, allows zero
        cur_req = "R7";
        scl = 1'b1;
        do_write(8'h06);
        chk(rd_data[2:0] === 3'd5, "R7", int'(rd_data[2:0]), 5);
        do_write(8'h00);
        chk(rd_data[2:0] === 3'd0, "R7", int'(rd_data[2:0]), 0);
        scl = 1'b0;

        // R8: synchronous format ignores writes
        cur_req = "R8";
        fmt = 1'b0;
        do_write(8'h04);
        chk(rd_data[2:0] === 3'd0, "R8", int'(rd_data[2:0]), 0);

        // R5: synchronous lengths, code programmed in I2C-style format first
        for (int c = 0; c < 8; c++) begin
            cur_req = "R5";
            fmt = 1'b1;
            do_write(8'(c));
            fmt = 1'b0;
            step();
            run_frame(c % 3, n);
            chk(n == frame_len(c, 1'b0), "R5", n, frame_len(c, 1'b0));
            step();
        end

        // R11: bit strobes while idle do nothing
        cur_req = "R11";
        fmt = 1'b1;
        do_write(8'h04);
        bit_done = 1'b1; step(); step(); bit_done = 1'b0;
        chk(rd_data[2:0] === 3'd4 && frame_done === 1'b0, "R11", int'(rd_data[2:0]), 4);
        run_frame(0, n);
        chk(n == 5, "R11", n, 5);
        step();

        // R1: soft reset in mid-frame
        cur_req = "R1";
        do_write(8'h06);
        start = 1'b1; step(); start = 1'b0;
        bit_done = 1'b1; step(); step(); bit_done = 1'b0;
        soft_rst = 1'b1; bit_done = 1'b1;
        step();
        soft_rst = 1'b0; bit_done = 1'b0;
        chk(rd_data === 4'b1000 && frame_done === 1'b0, "R1", int'(rd_data), 8);
        bit_done = 1'b1; step(); bit_done = 1'b0;
        chk(frame_done === 1'b0, "R1", int'(frame_done), 0);
        step();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule